// File: doc/BRIEF.md
# Synchronous Serial Clock Generator

This block produces the clock that runs beside transmitted serial data when a serial port works as a synchronous master. A shift-register peripheral can then latch the outgoing bits, and the port can capture return data on its receive line at the same moment. A transmitter and a baud generator outside the block supply two single-cycle timing marks, one at the start of every bit period and one at its middle. The transmitter also reports the phase of the frame for the bit that is starting (idle, start, data or stop) and whether that data bit is the last one of the word.

The block issues one full clock period for each data bit that is clocked. It issues none during start bits, stop bits or idle time. It can also leave out the pulse on the final data bit. Polarity and phase are set by two configuration inputs. A receive-sample strobe marks the cycle in which the receive line should be captured, and it appears only for bits that carry a clock pulse.

Top module: `sync_sclk_gen`

## Requirements
- R1: While the reset is held and after it is released, `sclk_o` equals `cpol_i` and `rx_sample_o` is 0.
- R2: A bit whose phase code is idle (0), start (1) or stop (3) produces no clock pulse and no receive strobe: `sclk_o` stays equal to `cpol_i` for that whole bit.
- R3: A data bit (phase code 2) that has `last_bit_i` high produces no pulse and no strobe when `last_pulse_en_i` is 0. It is clocked normally when `last_pulse_en_i` is 1.
- R4: When no pulse is in progress, `sclk_o` rests at the level of `cpol_i` and follows changes of `cpol_i`.
- R5: With phase 0 latched for a clocked bit, `sclk_o` stays at rest from the cycle after the bit tick until the cycle after the mid tick. It then holds the inverted level until the cycle after the next bit tick. The first edge, at mid-bit, is the sampling edge.
- R6: With phase 1 latched for a clocked bit, `sclk_o` holds the inverted level from the cycle after the bit tick until the cycle after the mid tick, and then rests. The second edge, at mid-bit, is the sampling edge.
- R7: `rx_sample_o` is a single-cycle pulse in the cycle after the mid tick of each clocked bit, and it never appears for any other bit.
- R8: `cpha_i` is sampled at each bit tick. A change of `cpha_i` within a bit does not alter that bit's waveform.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bit_tick_i | input | 1 | Single-cycle mark at the start of a bit period |
| mid_tick_i | input | 1 | Single-cycle mark at the middle of a bit period |
| phase_i | input | 2 | Frame phase of the bit starting at this tick: 0 idle, 1 start, 2 data, 3 stop |
| last_bit_i | input | 1 | The starting data bit is the last of the word |
| cpol_i | input | 1 | Rest level of the clock |
| cpha_i | input | 1 | 0: pulse in the second half of the bit; 1: pulse in the first half |
| last_pulse_en_i | input | 1 | Allow a clock pulse on the last data bit |
| sclk_o | output | 1 | Generated serial clock |
| rx_sample_o | output | 1 | Strobe for capturing the receive line |

## Verification
The bench targets the last data bit with the pulse disabled. A design that ignored the enable would give an extra edge pair and a spurious strobe. It also targets the boundary between the final data bit and the stop bit, where a clock left inverted would stretch into the stop bit. Mid-bit flips of the phase input show whether a design reads the phase input live instead of its latched copy, since such a design would cut the pulse short or leave an extra edge. Polarity changes during idle time and random bit lengths down to two cycles per half test the rest level and the strobe timing, where an early or doubled strobe would show.

// File: rtl/sync_sclk_pkg.sv
package sync_sclk_pkg;

  localparam int unsigned PHASE_W = 2;

  typedef enum logic [PHASE_W-1:0] {
    PH_IDLE  = 2'd0,
    PH_START = 2'd1,
    PH_DATA  = 2'd2,
    PH_STOP  = 2'd3
  } frame_phase_e;

  localparam int unsigned RST_STAGES = 2;

endpackage

// File: rtl/sck_rst_sync.sv
module sck_rst_sync #(
  parameter int unsigned STAGES = sync_sclk_pkg::RST_STAGES
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_sync_no = chain_q[STAGES-1];

endmodule

// File: rtl/sck_bit_tracker.sv
module sck_bit_tracker
  import sync_sclk_pkg::*;
(
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         bit_tick_i,
  input  frame_phase_e phase_i,
  input  logic         last_bit_i,
  input  logic         last_pulse_en_i,
  input  logic         cpha_i,
  output logic         eligible_o,
  output logic         active_o,
  output logic         cpha_lat_o
);

  logic active_q, active_d;
  logic cpha_q, cpha_d;
  logic elig;

  always_comb begin
    elig = (phase_i == PH_DATA) && (!last_bit_i || last_pulse_en_i);
  end

  always_comb begin
    active_d = active_q;
    cpha_d   = cpha_q;
    if (bit_tick_i) begin
      active_d = elig;
      cpha_d   = cpha_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cpha_q   <= 1'b0;
    end else begin
      active_q <= active_d;
      cpha_q   <= cpha_d;
    end
  end

  assign eligible_o = elig;
  assign active_o   = active_q;
  assign cpha_lat_o = cpha_q;

  // R2: a non-data phase never leaves the bit marked as clocked
  p_nondata_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_tick_i && phase_i != PH_DATA) |=> !active_q);

  // R8: latched phase only moves at a bit tick
  p_cpha_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_tick_i |=> $stable(cpha_q));

endmodule

// File: rtl/sck_level_shaper.sv
module sck_level_shaper (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_tick_i,
  input  logic mid_tick_i,
  input  logic eligible_i,
  input  logic cpha_now_i,
  input  logic active_i,
  input  logic cpha_lat_i,
  input  logic cpol_i,
  output logic sclk_o
);

  logic pulse_q, pulse_d;

  always_comb begin
    pulse_d = pulse_q;
    if (bit_tick_i) begin
      pulse_d = eligible_i && cpha_now_i;
    end else if (mid_tick_i) begin
      pulse_d = active_i && !cpha_lat_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pulse_q <= 1'b0;
    else         pulse_q <= pulse_d;
  end

  assign sclk_o = cpol_i ^ pulse_q;

  // R2/R3: an unclocked bit starts with the clock at rest
  p_unclocked_rest_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_tick_i && !eligible_i) |=> !pulse_q);

  // R5: phase 0 raises the pulse at mid-bit of a clocked bit
  p_cpha0_mid_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mid_tick_i && !bit_tick_i && active_i && !cpha_lat_i) |=> pulse_q);

  // R6: phase 1 drops the pulse at mid-bit
  p_cpha1_mid_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mid_tick_i && !bit_tick_i && cpha_lat_i) |=> !pulse_q);

endmodule

// File: rtl/sck_rx_strobe.sv
module sck_rx_strobe (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_tick_i,
  input  logic mid_tick_i,
  input  logic active_i,
  output logic strobe_o
);

  logic strobe_q, strobe_d;

  always_comb begin
    strobe_d = mid_tick_i && !bit_tick_i && active_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) strobe_q <= 1'b0;
    else         strobe_q <= strobe_d;
  end

  assign strobe_o = strobe_q;

  // R7: strobe only follows a mid tick
  p_strobe_after_mid_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_q |-> $past(mid_tick_i));

endmodule

// File: rtl/sync_sclk_gen.sv
module sync_sclk_gen
  import sync_sclk_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               bit_tick_i,
  input  logic               mid_tick_i,
  input  logic [PHASE_W-1:0] phase_i,
  input  logic               last_bit_i,
  input  logic               cpol_i,
  input  logic               cpha_i,
  input  logic               last_pulse_en_i,
  output logic               sclk_o,
  output logic               rx_sample_o
);

  logic         rst_n_int;
  logic         eligible;
  logic         active;
  logic         cpha_lat;
  frame_phase_e phase;

  assign phase = frame_phase_e'(phase_i);

  sck_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_n_int)
  );

  sck_bit_tracker u_track (
    .clk_i           (clk_i),
    .rst_ni          (rst_n_int),
    .bit_tick_i      (bit_tick_i),
    .phase_i         (phase),
    .last_bit_i      (last_bit_i),
    .last_pulse_en_i (last_pulse_en_i),
    .cpha_i          (cpha_i),
    .eligible_o      (eligible),
    .active_o        (active),
    .cpha_lat_o      (cpha_lat)
  );

  sck_level_shaper u_shape (
    .clk_i      (clk_i),
    .rst_ni     (rst_n_int),
    .bit_tick_i (bit_tick_i),
    .mid_tick_i (mid_tick_i),
    .eligible_i (eligible),
    .cpha_now_i (cpha_i),
    .active_i   (active),
    .cpha_lat_i (cpha_lat),
    .cpol_i     (cpol_i),
    .sclk_o     (sclk_o)
  );

  sck_rx_strobe u_strobe (
    .clk_i      (clk_i),
    .rst_ni     (rst_n_int),
    .bit_tick_i (bit_tick_i),
    .mid_tick_i (mid_tick_i),
    .active_i   (active),
    .strobe_o   (rx_sample_o)
  );

  // R1: in reset the outputs sit idle
  always_comb begin
    if (!rst_n_int) begin
      p_reset_idle_r1: assert (rx_sample_o == 1'b0);
    end
  end

  // R2: non-data bits leave the clock at its rest level
  p_no_pulse_outside_data_r2: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    (bit_tick_i && phase != PH_DATA) |=> (sclk_o == cpol_i));

  // R3: last bit with the pulse disabled stays at rest, no strobe
  p_last_skip_r3: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    (bit_tick_i && phase == PH_DATA && last_bit_i && !last_pulse_en_i)
      |=> (sclk_o == cpol_i && !rx_sample_o));

  // R5: phase 0 samples while the clock is inverted
  p_sample_level_cpha0_r5: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    (rx_sample_o && !cpha_lat) |-> (sclk_o != cpol_i));

  // R6: phase 1 samples once the clock is back at rest
  p_sample_level_cpha1_r6: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    (rx_sample_o && cpha_lat) |-> (sclk_o == cpol_i));

  // R7: the strobe lasts a single cycle
  p_strobe_single_r7: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    rx_sample_o |=> !rx_sample_o);

endmodule

// File: tb/sync_sclk_gen_tb_top.sv
module sync_sclk_gen_tb_top;

  logic       clk;
  logic       rst_n;
  logic       bit_tick;
  logic       mid_tick;
  logic [1:0] phase;
  logic       last_bit;
  logic       cpol;
  logic       cpha;
  logic       last_en;
  logic       sclk;
  logic       rx_sample;

  int n_checks = 0;
  int n_fail   = 0;
  logic  exp_lvl;
  logic  exp_strb;
  string lvl_tag;

  sync_sclk_gen dut_i (
    .clk_i           (clk),
    .rst_ni          (rst_n),
    .bit_tick_i      (bit_tick),
    .mid_tick_i      (mid_tick),
    .phase_i         (phase),
    .last_bit_i      (last_bit),
    .cpol_i          (cpol),
    .cpha_i          (cpha),
    .last_pulse_en_i (last_en),
    .sclk_o          (sclk),
    .rx_sample_o     (rx_sample)
  );

  initial clk = 1'b0;
  always #5ns clk = ~clk;

  function automatic logic bit_clocked(input logic [1:0] ph, input logic lst, input logic en);
    return (ph == 2'd2) && (!lst || en);
  endfunction

  task automatic check_bit(input string tag, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_outputs();
    check_bit(lvl_tag, sclk, exp_lvl);
    check_bit("R7", rx_sample, exp_strb);
  endtask

  // one bit period of 2*hl cycles; optional flip of cpha in the middle of the bit (R8)
  task automatic drive_bit(input logic [1:0] ph, input logic lst, input int hl, input bit flip);
    logic elig;
    logic cph;
    elig = 1'b0;
    cph  = 1'b0;
    for (int c = 0; c < 2 * hl; c++) begin
      @(negedge clk);
      check_outputs();
      bit_tick = (c == 0);
      mid_tick = (c == hl);
      exp_strb = 1'b0;
      if (c == 0) begin
        phase    = ph;
        last_bit = lst;
        elig     = bit_clocked(ph, lst, last_en);
        cph      = cpha;
        exp_lvl  = cpol ^ (elig & cph);
        if (!elig)     lvl_tag = (ph == 2'd2) ? "R3" : "R2";
        else if (flip) lvl_tag = "R8";
        else           lvl_tag = cph ? "R6" : "R5";
      end else if (c == hl) begin
        exp_lvl  = cpol ^ (elig & !cph);
        exp_strb = elig;
      end
      if (c == 1 && flip) cpha = ~cpha;
    end
  endtask

  task automatic idle_cycles(input int n, input logic new_cpol);
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      check_outputs();
      bit_tick = 1'b0;
      mid_tick = 1'b0;
      exp_strb = 1'b0;
      if (c == 0) begin
        cpol    = new_cpol;
        exp_lvl = new_cpol;
        lvl_tag = "R4";
      end
    end
  endtask

  task automatic run_frame(input int nbits, input int hl, input int nstop, input int flip_at);
    drive_bit(2'd1, 1'b0, hl, 1'b0);
    for (int b = 0; b < nbits; b++) begin
      drive_bit(2'd2, (b == nbits - 1), hl, (b == flip_at));
    end
    for (int s = 0; s < nstop; s++) begin
      drive_bit(2'd3, 1'b0, hl, 1'b0);
    end
  endtask

  initial begin
    #2ms;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual running expected done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_5A5A));
    rst_n    = 1'b0;
    bit_tick = 1'b0;
    mid_tick = 1'b0;
    phase    = 2'd0;
    last_bit = 1'b0;
    cpol     = 1'b1;
    cpha     = 1'b0;
    last_en  = 1'b0;
    exp_lvl  = 1'b1;
    exp_strb = 1'b0;
    lvl_tag  = "R1";
    repeat (3) @(negedge clk);
    check_bit("R1", sclk, 1'b1);
    check_bit("R1", rx_sample, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_bit("R1", sclk, 1'b1);
    check_bit("R1", rx_sample, 1'b0);

    // directed: idle-phase bit ticks, polarity change while idle
    drive_bit(2'd0, 1'b0, 3, 1'b0);
    idle_cycles(3, 1'b0);
    drive_bit(2'd0, 1'b1, 2, 1'b0);

    // directed: phase 0, last pulse off / on
    cpha = 1'b0; last_en = 1'b0;
    run_frame(8, 3, 1, -1);
    idle_cycles(4, 1'b0);
    last_en = 1'b1;
    run_frame(8, 2, 2, -1);
    idle_cycles(4, 1'b1);

    // directed: phase 1, last pulse off / on, shortest halves
    cpha = 1'b1; last_en = 1'b0;
    run_frame(9, 2, 1, -1);
    idle_cycles(3, 1'b1);
    last_en = 1'b1;
    run_frame(9, 4, 1, -1);
    idle_cycles(3, 1'b0);

    // directed: mid-bit flip of phase input
    cpha = 1'b0; last_en = 1'b1;
    run_frame(8, 3, 1, 2);
    idle_cycles(2, 1'b0);

    // random frames
    for (int f = 0; f < 40; f++) begin
      int hl;
      int nb;
      int ns;
      int fl;
      hl = 2 + int'($urandom_range(0, 4));
      nb = ($urandom_range(0, 1) == 0) ? 8 : 9;
      ns = 1 + int'($urandom_range(0, 1));
      fl = ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, nb - 1)) : -1;
      cpha    = 1'($urandom_range(0, 1));
      last_en = 1'($urandom_range(0, 1));
      run_frame(nb, hl, ns, fl);
      idle_cycles(1 + int'($urandom_range(0, 5)), 1'($urandom_range(0, 1)));
    end

    idle_cycles(2, cpol);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule